// File: doc/BRIEF.md
# Severity-Grouped Error Aggregation Controller

This block gathers one-cycle error pulses from on-chip error channels and answers each one according to the severity group it belongs to. There are three groups. Low-severity channels (group A) are fully programmable. For each channel, software chooses whether it raises an interrupt, which of the two interrupt levels it uses, and whether it pulls the external error pin. Medium/high channels (group B) always raise the high-level interrupt and always pull the pin. The most severe channels (group C) pull the pin only and never raise an interrupt. These channels belong to diagnostics that already stop the processor by another path.

Every channel has a sticky status bit. The bit latches whether or not its interrupt is enabled, and software clears it by writing a one to it. The error pin is active low. Once it drops, it stays low for a programmed number of prescaled ticks. It rises again only after that time has passed and software has written a release key. A force mode pulls the pin low so the external path can be tested for latent faults, and it leaves every status bit unchanged.

Software reaches the block through a plain register port: a write strobe with address and data, plus a combinational read. Register addresses are 32-bit words:

| Address | Contents |
|---|---|
| 0..2 | Group-A interrupt enables |
| 3..5 | Group-A pin enables |
| 6..8 | Group-A level select (1 = high level) |
| 9..11 | Group-A status (write-one-to-clear) |
| 12 | Group-B status (write-one-to-clear) |
| 13 | Group-C status (write-one-to-clear) |
| 14 | Timing: prescale divisor in bits 7:0, minimum low ticks in bits 15:8 |
| 15 | Pin release key: 0x5A in bits 7:0 |
| 16 | Force control: 0xA5 in bits 7:0 turns force on, any other value turns it off; the force state reads back in bit 0 |

Channel n of group A is bit n%32 of word n/32.

Top module: `sev_err_agg`

## Requirements
- R1: A group-A error pulse sets its status bit (address 9 + n/32, bit n%32) whatever the channel's interrupt and pin enables are.
- R2: irq_lo_o is the OR of group-A status bits whose interrupt enable is 1 and level bit is 0. irq_hi_o includes group-A status bits whose interrupt enable is 1 and level bit is 1.
- R3: Status bits are sticky and clear only when a one is written to them. An error arriving in the same cycle as the clear leaves the bit set.
- R4: A group-B error sets its status bit (address 12) and, from the next cycle, raises irq_hi_o and drives err_pin_n_o low. No enable can mask it.
- R5: A group-C error sets its status bit (address 13) and drives err_pin_n_o low, and it never raises either interrupt.
- R6: A group-A error drives err_pin_n_o low only when the channel's pin enable (address 3 + n/32) is 1.
- R7: Once low, err_pin_n_o stays low until at least min-low ticks have passed, where one tick is (prescale divisor + 1) clocks. After that, a write of 0x5A to address 15 releases it. An earlier write has no effect.
- R8: While force is on, err_pin_n_o is low and no status bit changes. Turning force off restores the pin state that was in effect before.
- R9: An interrupt output falls in the cycle after the write that clears the last pending enabled bit mapped to it.
- R10: After reset all status bits are 0, both interrupts are low, err_pin_n_o is high, and the timing register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_a_err_i | input | 96 | Group-A error pulses |
| grp_b_err_i | input | 32 | Group-B error pulses |
| grp_c_err_i | input | 32 | Group-C error pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 5 | Write word address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 5 | Read word address |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_lo_o | output | 1 | Low-level interrupt |
| irq_hi_o | output | 1 | High-level interrupt |
| err_pin_n_o | output | 1 | Active-low external error pin |

## Verification
A status bit stuck at 0 shows up in the cycle after the error: the status readback is zero and the interrupt never rises. A bit that clears by itself drops its interrupt without any write. A wrong level or enable mapping shows up one cycle after the error, as a pulse on the wrong interrupt output. The pin timer is checked at both edges of its window: a release key written too early must leave the pin low, and a key written after the window must raise it in the very next cycle. Force mode is checked by reading every status word back after force is exited.

// File: rtl/sea_pkg.sv
package sea_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam logic [7:0]  RELEASE_KEY = 8'h5A;
  localparam logic [7:0]  FORCE_KEY   = 8'hA5;
endpackage

// File: rtl/sea_sticky_bank.sv
module sea_sticky_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] st_o
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = (st_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  AST_STATUS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(set_i)) == $past(set_i))); // R1
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i))); // R3
endmodule

// File: rtl/sea_pin_timer.sv
module sea_pin_timer #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             rel_i,
  input  logic             force_i,
  input  logic [PRE_W-1:0] pre_div_i,
  input  logic [LOW_W-1:0] min_low_i,
  output logic             err_n_o
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LOW_W-1:0] cnt_q, cnt_d;
  logic             low_q, low_d;
  logic             tick, done;

  always_comb begin
    tick  = (pre_q == pre_div_i);
    done  = (cnt_q >= min_low_i);
    pre_d = tick ? '0 : pre_q + 1'b1;
    low_d = low_q;
    cnt_d = cnt_q;
    if (trig_i) begin
      low_d = 1'b1;
      cnt_d = '0;
    end else if (low_q && rel_i && done) begin
      low_d = 1'b0;
      cnt_d = '0;
    end else if (low_q && tick && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      low_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
      low_q <= low_d;
    end
  end

  assign err_n_o = ~(low_q | force_i);

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (low_q && !(rel_i && done)) |=> low_q); // R7
  AST_PIN_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> !err_n_o); // R6
  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(low_q) |-> ($past(rel_i) && $past(done))); // R7
endmodule

// File: rtl/sev_err_agg.sv
module sev_err_agg #(
  parameter int unsigned A_CH   = 96,
  parameter int unsigned B_CH   = 32,
  parameter int unsigned C_CH   = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned LOW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [A_CH-1:0]   grp_a_err_i,
  input  logic [B_CH-1:0]   grp_b_err_i,
  input  logic [C_CH-1:0]   grp_c_err_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o,
  output logic              err_pin_n_o
);
  import sea_pkg::*;

  localparam int unsigned NW    = A_CH / WORD_W;
  localparam int unsigned AD_IE = 0;
  localparam int unsigned AD_PE = NW;
  localparam int unsigned AD_LV = 2 * NW;
  localparam int unsigned AD_SA = 3 * NW;
  localparam int unsigned AD_SB = 4 * NW;
  localparam int unsigned AD_SC = AD_SB + 1;
  localparam int unsigned AD_TM = AD_SB + 2;
  localparam int unsigned AD_KY = AD_SB + 3;
  localparam int unsigned AD_FC = AD_SB + 4;
  localparam int unsigned TM_W  = PRE_W + LOW_W;

  // reset: async assert, sync release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [A_CH-1:0] ie_q, ie_d, pe_q, pe_d, lv_q, lv_d, clr_a, st_a;
  logic [B_CH-1:0] clr_b, st_b;
  logic [C_CH-1:0] clr_c, st_c;
  logic [TM_W-1:0] tm_q, tm_d;
  logic            frc_q, frc_d, rel, trig;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned t);
    return reg_we_i && (a == ADDR_W'(t));
  endfunction

  always_comb begin
    ie_d  = ie_q;
    pe_d  = pe_q;
    lv_d  = lv_q;
    clr_a = '0;
    for (int w = 0; w < NW; w++) begin
      if (hit(reg_waddr_i, AD_IE + w)) ie_d[w*WORD_W +: WORD_W] = reg_wdata_i;
      if (hit(reg_waddr_i, AD_PE + w)) pe_d[w*WORD_W +: WORD_W] = reg_wdata_i;
      if (hit(reg_waddr_i, AD_LV + w)) lv_d[w*WORD_W +: WORD_W] = reg_wdata_i;
      if (hit(reg_waddr_i, AD_SA + w)) clr_a[w*WORD_W +: WORD_W] = reg_wdata_i;
    end
    clr_b = hit(reg_waddr_i, AD_SB) ? reg_wdata_i[B_CH-1:0] : '0;
    clr_c = hit(reg_waddr_i, AD_SC) ? reg_wdata_i[C_CH-1:0] : '0;
    tm_d  = hit(reg_waddr_i, AD_TM) ? reg_wdata_i[TM_W-1:0] : tm_q;
    frc_d = hit(reg_waddr_i, AD_FC) ? (reg_wdata_i[7:0] == FORCE_KEY) : frc_q;
    rel   = hit(reg_waddr_i, AD_KY) && (reg_wdata_i[7:0] == RELEASE_KEY);
    trig  = |(grp_a_err_i & pe_q) | (|grp_b_err_i) | (|grp_c_err_i);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ie_q  <= '0;
      pe_q  <= '0;
      lv_q  <= '0;
      tm_q  <= '0;
      frc_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      pe_q  <= pe_d;
      lv_q  <= lv_d;
      tm_q  <= tm_d;
      frc_q <= frc_d;
    end
  end

  sea_sticky_bank #(.W(A_CH)) u_st_a (.clk(clk), .rst_n(rst_s_n), .set_i(grp_a_err_i), .clr_i(clr_a), .st_o(st_a));
  sea_sticky_bank #(.W(B_CH)) u_st_b (.clk(clk), .rst_n(rst_s_n), .set_i(grp_b_err_i), .clr_i(clr_b), .st_o(st_b));
  sea_sticky_bank #(.W(C_CH)) u_st_c (.clk(clk), .rst_n(rst_s_n), .set_i(grp_c_err_i), .clr_i(clr_c), .st_o(st_c));

  sea_pin_timer #(.PRE_W(PRE_W), .LOW_W(LOW_W)) u_pin (
    .clk(clk), .rst_n(rst_s_n), .trig_i(trig), .rel_i(rel), .force_i(frc_q),
    .pre_div_i(tm_q[PRE_W-1:0]), .min_low_i(tm_q[TM_W-1:PRE_W]), .err_n_o(err_pin_n_o));

  assign irq_lo_o = |(st_a & ie_q & ~lv_q);
  assign irq_hi_o = |(st_a & ie_q & lv_q) | (|st_b);

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (reg_raddr_i == ADDR_W'(AD_IE + w)) reg_rdata_o = ie_q[w*WORD_W +: WORD_W];
      if (reg_raddr_i == ADDR_W'(AD_PE + w)) reg_rdata_o = pe_q[w*WORD_W +: WORD_W];
      if (reg_raddr_i == ADDR_W'(AD_LV + w)) reg_rdata_o = lv_q[w*WORD_W +: WORD_W];
      if (reg_raddr_i == ADDR_W'(AD_SA + w)) reg_rdata_o = st_a[w*WORD_W +: WORD_W];
    end
    if (reg_raddr_i == ADDR_W'(AD_SB)) reg_rdata_o = 32'(st_b);
    if (reg_raddr_i == ADDR_W'(AD_SC)) reg_rdata_o = 32'(st_c);
    if (reg_raddr_i == ADDR_W'(AD_TM)) reg_rdata_o = 32'(tm_q);
    if (reg_raddr_i == ADDR_W'(AD_FC)) reg_rdata_o = {31'd0, frc_q};
  end

  AST_GRPB_IRQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|grp_b_err_i) |=> irq_hi_o); // R4
  AST_GRPB_PIN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|grp_b_err_i) |=> !err_pin_n_o); // R4
  AST_GRPC_PIN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|grp_c_err_i) |=> !err_pin_n_o); // R5
  AST_FORCE_PIN: assert property (@(posedge clk) disable iff (!rst_s_n)
    frc_q |-> !err_pin_n_o); // R8
endmodule

// File: tb/sev_err_agg_test.sv
module sev_err_agg_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [95:0]  ga;
  logic [31:0]  gb, gc;
  logic         we;
  logic [4:0]   wa, ra;
  logic [31:0]  wd;
  logic [31:0]  rd;
  logic         ilo, ihi, pin_n;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  sev_err_agg uut (
    .clk(clk), .rst_n(rst_n), .grp_a_err_i(ga), .grp_b_err_i(gb), .grp_c_err_i(gc),
    .reg_we_i(we), .reg_waddr_i(wa), .reg_wdata_i(wd), .reg_raddr_i(ra),
    .reg_rdata_o(rd), .irq_lo_o(ilo), .irq_hi_o(ihi), .err_pin_n_o(pin_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; wa = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdw(input logic [4:0] a, output logic [31:0] d);
    ra = a; #0.5; d = rd;
  endtask

  task automatic pulse(input logic [95:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk); ga = a; gb = b; gc = c;
    @(negedge clk); ga = '0; gb = '0; gc = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rdw(5'd9, v);  chk("R10 status A0", v, 0);
    rdw(5'd12, v); chk("R10 status B", v, 0);
    rdw(5'd14, v); chk("R10 timing", v, 0);
    chk("R10 irqs", {30'd0, ilo, ihi}, 0);
    chk("R10 pin", {31'd0, pin_n}, 1);
  endtask

  task automatic t_latch_no_enable;
    logic [31:0] v;
    pulse(96'h1 << 40, 0, 0);
    rdw(5'd10, v); chk("R1 status latched with enables off", v, 32'h100);
    chk("R1 no irq when disabled", {30'd0, ilo, ihi}, 0);
    chk("R6 pin not driven without pin enable", {31'd0, pin_n}, 1);
    wr(5'd10, 32'h100);
  endtask

  task automatic t_routing;
    logic [31:0] v;
    wr(5'd0, 32'h0000_0003);
    wr(5'd8, 32'h8000_0000);
    wr(5'd2, 32'h8000_0000);
    wr(5'd6, 32'h0000_0002);
    pulse(96'h1, 0, 0);
    chk("R2 low level routes to irq_lo", {30'd0, ilo, ihi}, 32'b10);
    pulse(96'h2, 0, 0);
    chk("R2 both levels", {30'd0, ilo, ihi}, 32'b11);
    wr(5'd9, 32'h2);
    chk("R9 irq_hi falls after clear", {30'd0, ilo, ihi}, 32'b10);
    pulse(96'h1 << 95, 0, 0);
    chk("R2 high level word 2", {31'd0, ihi}, 1);
    @(negedge clk); we = 1'b1; wa = 5'd9; wd = 32'h1; ga = 96'h1;
    @(negedge clk); we = 1'b0; ga = '0;
    rdw(5'd9, v); chk("R3 set wins over same-cycle clear", v, 32'h1);
    chk("R3 irq_lo still pending", {31'd0, ilo}, 1);
    wr(5'd9, 32'hFFFF_FFFE);
    rdw(5'd9, v); chk("R3 clearing other bits leaves bit", v, 32'h1);
    chk("R9 irq_lo held just before clear", {31'd0, ilo}, 1);
    wr(5'd9, 32'h1);
    chk("R9 irq_lo falls cycle after clear", {31'd0, ilo}, 0);
    wr(5'd11, 32'h8000_0000);
    chk("R9 irq_hi falls", {31'd0, ihi}, 0);
  endtask

  task automatic t_grp_b;
    logic [31:0] v;
    pulse(0, 32'h10, 0);
    chk("R4 group B raises irq_hi", {31'd0, ihi}, 1);
    chk("R4 group B drives pin", {31'd0, pin_n}, 0);
    rdw(5'd12, v); chk("R4 group B status", v, 32'h10);
    wr(5'd12, 32'h10);
    chk("R4 irq_hi clears", {31'd0, ihi}, 0);
    wr(5'd15, 32'h5A);
    chk("R7 release with zero minimum", {31'd0, pin_n}, 1);
  endtask

  task automatic t_grp_c;
    logic [31:0] v;
    pulse(0, 0, 32'h8000_0001);
    chk("R5 group C pin", {31'd0, pin_n}, 0);
    chk("R5 group C no irq", {30'd0, ilo, ihi}, 0);
    rdw(5'd13, v); chk("R5 group C status", v, 32'h8000_0001);
    wr(5'd13, 32'hFFFF_FFFF);
    wr(5'd15, 32'h5A);
  endtask

  task automatic t_pin_timer;
    wr(5'd3, 32'h4);
    wr(5'd14, 32'h0000_0301);
    pulse(96'h4, 0, 0);
    chk("R6 pin enable drives pin", {31'd0, pin_n}, 0);
    wr(5'd15, 32'h5A);
    chk("R7 early release ignored", {31'd0, pin_n}, 0);
    repeat (12) @(negedge clk);
    wr(5'd15, 32'h33);
    chk("R7 wrong key ignored", {31'd0, pin_n}, 0);
    wr(5'd15, 32'h5A);
    chk("R7 release after window", {31'd0, pin_n}, 1);
    wr(5'd9, 32'h4);
  endtask

  task automatic t_force;
    logic [31:0] v;
    wr(5'd16, 32'hA5);
    chk("R8 force pulls pin", {31'd0, pin_n}, 0);
    rdw(5'd16, v); chk("R8 force state", v, 1);
    wr(5'd16, 32'h0);
    chk("R8 pin restored", {31'd0, pin_n}, 1);
    for (int a = 9; a <= 13; a++) begin
      rdw(5'(a), v); chk("R8 no status from force", v, 0);
    end
    chk("R8 no irq from force", {30'd0, ilo, ihi}, 0);
  endtask

  initial begin
    #50000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ga = '0; gb = '0; gc = '0; we = 1'b0; wa = '0; wd = '0; ra = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch_no_enable();
    t_routing();
    t_grp_b();
    t_grp_c();
    t_pin_timer();
    t_force();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule